// File: doc/BRIEF.md
# Atomic Store Access Checker

This block decides, once per request, whether a conditional-store (atomic compare-and-store) access may go ahead. It receives the outcome of the address translation for the target: a fault code, read and write permission bits and a cache attribute class. It also receives the atomic-operation control word and a flag that says whether a data cache is present. One cycle later it reports either permission to proceed or an exception cause, together with the faulting virtual address.

The checks run in a fixed priority. A translation fault wins over everything. A missing permission comes next. Last comes the attribute policy, where a two-bit field of the control word, chosen by the attribute class, must be non-zero. Pages in cache-isolate mode are always refused. Classes with no policy field pass. When no data cache exists, every page is judged as a bypass page.

Top module: `atomic_store_checker`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `rsp_valid_o`, `rsp_ok_o`, `rsp_cause_o` and `rsp_vaddr_o` are all zero.
- R2: A high `req_i` sampled on a clock edge gives `rsp_valid_o` high for exactly the following cycle. With no request, `rsp_valid_o` stays low.
- R3: A non-zero `xlat_fault_i` means the translation failed. The response is then a fault carrying that same code as its cause, whatever the permissions, attribute and control word are.
- R4: With no translation fault, if either `perm_rd_i` or `perm_wr_i` is low, the response is a fault with cause 29 (store denied). This holds even when only read permission is missing, and it wins over the attribute policy.
- R5: With a data cache present, attribute classes 0 (bypass), 1 (write-through) and 2 (write-back) select control bits [1:0], [3:2] and [5:4] respectively. A selected field of zero gives a fault with cause 3 (load/store error). A non-zero field allows the access.
- R6: With a data cache present, attribute class 3 (cache isolate) always gives a fault with cause 3, for every control word.
- R7: With a data cache present, attribute classes 4 to 7 always allow the access, for every control word.
- R8: With `dcache_en_i` low, every attribute class, isolate included, is judged by control bits [1:0] as a bypass page.
- R9: Every fault response returns the request's `vaddr_i` on `rsp_vaddr_o`. An allowed access returns `rsp_ok_o` high with cause 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; inputs below are sampled with it |
| xlat_fault_i | input | CAUSE_W (6) | Translation fault code, zero when translation succeeded |
| perm_rd_i | input | 1 | Page grants read |
| perm_wr_i | input | 1 | Page grants write |
| attr_cls_i | input | 3 | Cache attribute class (0 bypass, 1 write-through, 2 write-back, 3 isolate, 4-7 no policy) |
| ctl_i | input | FIELD_W*NUM_FIELDS (6) | Atomic-operation control word |
| dcache_en_i | input | 1 | A data cache is configured |
| vaddr_i | input | VA_W (32) | Target virtual address |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_ok_o | output | 1 | Access may proceed |
| rsp_cause_o | output | CAUSE_W (6) | Exception cause when refused, else zero |
| rsp_vaddr_o | output | VA_W (32) | Faulting virtual address when refused, else zero |

## Verification
The properties assume that a translation fault code is only ever non-zero for a real fault. They also assume that the store-denied and load/store-error codes are distinct from the fault codes the translation stage delivers, so a cause value on the output points to one rule only. The sweep respects this by using a single fault code, 18, that matches neither fixed cause. It crosses that code and the no-fault case with all permission pairs, all eight attribute classes, both cache settings and all 64 control words. Each request is followed by an idle cycle, so that the response strobe can be seen to fall.

// File: rtl/atomchk_pkg.sv
package atomchk_pkg;

    localparam int unsigned CAUSE_W = 6;
    localparam int unsigned CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_BYPASS  = 3'd0,
        CLS_WTHRU   = 3'd1,
        CLS_WBACK   = 3'd2,
        CLS_ISOLATE = 3'd3
    } attr_cls_e;

    typedef struct packed {
        logic               fail;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

    localparam verdict_t VERDICT_PASS = '{fail: 1'b0, cause: '0};

    function automatic verdict_t make_fail(input logic [CAUSE_W-1:0] code);
        verdict_t v;
        v.fail  = 1'b1;
        v.cause = code;
        return v;
    endfunction

    // Earlier stage wins when both report a failure.
    function automatic verdict_t pick_first(input verdict_t hi, input verdict_t lo);
        return hi.fail ? hi : lo;
    endfunction

endpackage

// File: rtl/atomchk_perm_stage.sv
module atomchk_perm_stage
    import atomchk_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29
) (
    input  logic [CAUSE_W-1:0] fault_code,
    input  logic               can_read,
    input  logic               can_write,
    output verdict_t           verdict
);
    logic xlat_failed;
    logic perm_short;

    assign xlat_failed = (fault_code != '0);
    assign perm_short  = !(can_read && can_write);

    always_comb begin
        if (xlat_failed) begin
            verdict = make_fail(fault_code);
        end else if (perm_short) begin
            verdict = make_fail(CAUSE_STORE_DENY);
        end else begin
            verdict = VERDICT_PASS;
        end
    end
endmodule

// File: rtl/atomchk_attr_stage.sv
module atomchk_attr_stage
    import atomchk_pkg::*;
#(
    parameter int unsigned        FIELD_W       = 2,
    parameter int unsigned        NUM_FIELDS    = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_LS_FAIL = 6'd3
) (
    input  logic [FIELD_W*NUM_FIELDS-1:0] ctl,
    input  logic [CLS_W-1:0]              cls,
    input  logic                          dcache_en,
    output verdict_t                      verdict
);
    logic [NUM_FIELDS-1:0] field_zero;
    attr_cls_e             eff_cls;

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        assign field_zero[k] = (ctl[k*FIELD_W +: FIELD_W] == '0);
    end

    // Without a data cache every page is treated as a bypass page.
    assign eff_cls = dcache_en ? attr_cls_e'(cls) : CLS_BYPASS;

    always_comb begin
        verdict = VERDICT_PASS;
        if (32'(eff_cls) < NUM_FIELDS) begin
            if (field_zero[eff_cls]) begin
                verdict = make_fail(CAUSE_LS_FAIL);
            end
        end else if (eff_cls == CLS_ISOLATE) begin
            verdict = make_fail(CAUSE_LS_FAIL);
        end
    end
endmodule

// File: rtl/atomchk_resp_reg.sv
module atomchk_resp_reg
    import atomchk_pkg::*;
#(
    parameter int unsigned VA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  verdict_t           verdict,
    input  logic [VA_W-1:0]    vaddr,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [VA_W-1:0]    rsp_vaddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_cause <= '0;
            rsp_vaddr <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_ok    <= !verdict.fail;
                rsp_cause <= verdict.fail ? verdict.cause : '0;
                rsp_vaddr <= verdict.fail ? vaddr : '0;
            end else begin
                rsp_ok    <= 1'b0;
                rsp_cause <= '0;
                rsp_vaddr <= '0;
            end
        end
    end
endmodule

// File: rtl/atomic_store_checker.sv
module atomic_store_checker
    import atomchk_pkg::*;
#(
    parameter int unsigned        VA_W             = 32,
    parameter int unsigned        FIELD_W          = 2,
    parameter int unsigned        NUM_FIELDS       = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29,
    parameter logic [CAUSE_W-1:0] CAUSE_LS_FAIL    = 6'd3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_i,
    input  logic [CAUSE_W-1:0]            xlat_fault_i,
    input  logic                          perm_rd_i,
    input  logic                          perm_wr_i,
    input  logic [CLS_W-1:0]              attr_cls_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] ctl_i,
    input  logic                          dcache_en_i,
    input  logic [VA_W-1:0]               vaddr_i,
    output logic                          rsp_valid_o,
    output logic                          rsp_ok_o,
    output logic [CAUSE_W-1:0]            rsp_cause_o,
    output logic [VA_W-1:0]               rsp_vaddr_o
);
    verdict_t perm_v;
    verdict_t attr_v;
    verdict_t final_v;

    atomchk_perm_stage #(
        .CAUSE_STORE_DENY(CAUSE_STORE_DENY)
    ) u_perm (
        .fault_code(xlat_fault_i),
        .can_read  (perm_rd_i),
        .can_write (perm_wr_i),
        .verdict   (perm_v)
    );

    atomchk_attr_stage #(
        .FIELD_W      (FIELD_W),
        .NUM_FIELDS   (NUM_FIELDS),
        .CAUSE_LS_FAIL(CAUSE_LS_FAIL)
    ) u_attr (
        .ctl      (ctl_i),
        .cls      (attr_cls_i),
        .dcache_en(dcache_en_i),
        .verdict  (attr_v)
    );

    assign final_v = pick_first(perm_v, attr_v);

    atomchk_resp_reg #(
        .VA_W(VA_W)
    ) u_resp (
        .clk      (clk),
        .rst      (rst),
        .fire     (req_i),
        .verdict  (final_v),
        .vaddr    (vaddr_i),
        .rsp_valid(rsp_valid_o),
        .rsp_ok   (rsp_ok_o),
        .rsp_cause(rsp_cause_o),
        .rsp_vaddr(rsp_vaddr_o)
    );
endmodule

// File: rtl/atomchk_sva.sv
module atomchk_sva
    import atomchk_pkg::*;
#(
    parameter int unsigned        VA_W             = 32,
    parameter int unsigned        FIELD_W          = 2,
    parameter int unsigned        NUM_FIELDS       = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29,
    parameter logic [CAUSE_W-1:0] CAUSE_LS_FAIL    = 6'd3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          req_i,
    input logic [CAUSE_W-1:0]            xlat_fault_i,
    input logic                          perm_rd_i,
    input logic                          perm_wr_i,
    input logic [CLS_W-1:0]              attr_cls_i,
    input logic [FIELD_W*NUM_FIELDS-1:0] ctl_i,
    input logic                          dcache_en_i,
    input logic [VA_W-1:0]               vaddr_i,
    input logic                          rsp_valid_o,
    input logic                          rsp_ok_o,
    input logic [CAUSE_W-1:0]            rsp_cause_o,
    input logic [VA_W-1:0]               rsp_vaddr_o
);
    logic clean;
    assign clean = req_i && (xlat_fault_i == '0) && perm_rd_i && perm_wr_i;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !rsp_valid_o);

    assert_xlat_fault_first_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i && xlat_fault_i != '0) |=>
            (!rsp_ok_o && rsp_cause_o == $past(xlat_fault_i)));

    assert_perm_denied_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i && xlat_fault_i == '0 && !(perm_rd_i && perm_wr_i)) |=>
            (!rsp_ok_o && rsp_cause_o == CAUSE_STORE_DENY));

    assert_isolate_refused_R6: assert property (@(posedge clk) disable iff (rst)
        (clean && dcache_en_i && attr_cls_i == CLS_ISOLATE) |=>
            (!rsp_ok_o && rsp_cause_o == CAUSE_LS_FAIL));

    assert_no_policy_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (clean && dcache_en_i && attr_cls_i >= 3'd4) |=> rsp_ok_o);

    assert_no_cache_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (clean && !dcache_en_i) |=>
            (rsp_ok_o == ($past(ctl_i[FIELD_W-1:0]) != '0)));

    assert_fault_vaddr_R9: assert property (@(posedge clk) disable iff (rst)
        req_i |=> (rsp_ok_o || rsp_vaddr_o == $past(vaddr_i)));

    assert_ok_clean_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_ok_o |-> (rsp_valid_o && rsp_cause_o == '0 && rsp_vaddr_o == '0));
endmodule

bind atomic_store_checker atomchk_sva #(
    .VA_W            (VA_W),
    .FIELD_W         (FIELD_W),
    .NUM_FIELDS      (NUM_FIELDS),
    .CAUSE_STORE_DENY(CAUSE_STORE_DENY),
    .CAUSE_LS_FAIL   (CAUSE_LS_FAIL)
) u_sva (.*);

// File: tb/atomic_store_checker_tb.sv
module atomic_store_checker_tb;
    localparam int FAULT_CODE = 18;
    localparam int DENY       = 29;
    localparam int LSERR      = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [5:0]  xlat_fault_i = '0;
    logic        perm_rd_i = 1'b0;
    logic        perm_wr_i = 1'b0;
    logic [2:0]  attr_cls_i = '0;
    logic [5:0]  ctl_i = '0;
    logic        dcache_en_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        rsp_valid_o;
    logic        rsp_ok_o;
    logic [5:0]  rsp_cause_o;
    logic [31:0] rsp_vaddr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    atomic_store_checker u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .xlat_fault_i(xlat_fault_i),
        .perm_rd_i(perm_rd_i), .perm_wr_i(perm_wr_i), .attr_cls_i(attr_cls_i),
        .ctl_i(ctl_i), .dcache_en_i(dcache_en_i), .vaddr_i(vaddr_i),
        .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o),
        .rsp_cause_o(rsp_cause_o), .rsp_vaddr_o(rsp_vaddr_o)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input int f, input bit rd, input bit wr, input int cls,
                            input bit dc, input int ctl, input logic [31:0] va);
        int    ecls;
        bit    eok;
        int    ecause;
        string tag;
        xlat_fault_i = 6'(f);
        perm_rd_i    = rd;
        perm_wr_i    = wr;
        attr_cls_i   = 3'(cls);
        dcache_en_i  = dc;
        ctl_i        = 6'(ctl);
        vaddr_i      = va;
        req_i        = 1'b1;
        // Expected result from the requirements.
        ecls = dc ? cls : 0;
        eok = 1'b1; ecause = 0;
        if (f != 0) begin
            eok = 0; ecause = f; tag = "R3";
        end else if (!(rd && wr)) begin
            eok = 0; ecause = DENY; tag = "R4";
        end else if (ecls <= 2) begin
            tag = dc ? "R5" : "R8";
            if (((ctl >> (2 * ecls)) & 3) == 0) begin
                eok = 0; ecause = LSERR;
            end
        end else if (ecls == 3) begin
            eok = 0; ecause = LSERR; tag = "R6";
        end else begin
            tag = "R7";
        end
        @(negedge clk);
        req_i = 1'b0;
        check({tag, "/R9/R2 response"},
              {rsp_valid_o, rsp_ok_o, rsp_cause_o, rsp_vaddr_o},
              {1'b1, eok, 6'(ecause), eok ? 32'h0 : va});
        @(negedge clk);
        check("R2 strobe drop", {39'h0, rsp_valid_o}, 40'h0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int idx = 0;
        @(negedge clk);
        check("R1 in reset", {rsp_valid_o, rsp_ok_o, rsp_cause_o, rsp_vaddr_o}, 40'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {rsp_valid_o, rsp_ok_o, rsp_cause_o, rsp_vaddr_o}, 40'h0);
        @(negedge clk);
        check("R2 idle", {39'h0, rsp_valid_o}, 40'h0);
        for (int fi = 0; fi < 2; fi++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int dc = 0; dc < 2; dc++) begin
                    for (int cl = 0; cl < 8; cl++) begin
                        for (int ct = 0; ct < 64; ct++) begin
                            run_case(fi ? FAULT_CODE : 0, pm[1], pm[0], cl, dc[0], ct,
                                     32'hA000_0000 ^ (32'(idx) * 32'h0001_0345));
                            idx++;
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule